// File: doc/BRIEF.md
# Mixed-Width Dual-Port Block RAM

A behavioural, synthesizable model of a block memory with two independent read/write ports, A and B, sharing one clock. Each port is built with its own data width, chosen from 1, 2, 4, 9, 18 or 36 bits, and both widths index the same flat bit array. A wider port therefore sees several narrower words side by side, and a write through one port is visible through the other at the matching bit positions.

Every port has a clock enable, an address, write data, up to four 9-bit lane write enables and a registered read output. The read register has a synchronous reset value and a power-up value, both parameters. A per-port write policy fixes what the read register shows on a cycle in which that port writes: its previous value, the freshly merged word, or the contents from before the write. The array starts from a parameter image. If both ports write the same bit in the same cycle, the stored result is undefined, and users must avoid that case. In this model port B's value lands.

Top module: `tdp_mw_ram`

## Requirements
- R1: With `ADDR1_W` address bits at width 1, a port of width 1, 2, 4, 9, 18 or 36 has `ADDR1_W` minus 0, 1, 2, 3, 4 or 5 address bits. Word n of a port of width W occupies flat array bits n*W to n*W+W-1. Both ports address the same flat array of 9*2^(`ADDR1_W`-3) bits.
- R2: Enable bit k of `be_x` governs word bits 9k to 9k+8 of a port that is 9 bits or wider. A port narrower than 9 bits uses only bit 0. Enable bits above the port's lane count are ignored. Only the enabled lanes are written. An enabled port with none of its lanes enabled performs a plain read.
- R3: While `ce_x` is low, that port writes nothing, and its read output keeps its value whatever the reset, enables, address and data inputs do.
- R4: At a rising edge with `ce_x` high, the word at `addr_x` is loaded into `dout_x`. It is visible from that edge until the next enabled edge.
- R5: Write policy 0 (hold): on an enabled cycle in which the port writes, `dout_x` keeps its previous value.
- R6: Write policy 1 (new data): on a writing cycle, `dout_x` shows the merged word. Enabled lanes carry `din_x` and the other lanes keep the stored contents.
- R7: Write policy 2 (old data): on a writing cycle, `dout_x` shows the word as stored before that write.
- R8: When one port writes a cell and the other port reads overlapping bits in the same cycle, the reading port gets the contents from before the write.
- R9: With `ce_x` and `srst_x` both high, `dout_x` loads the port's reset value and any enabled write still updates the array. With `ce_x` low, `srst_x` has no effect.
- R10: Before the first enabled edge, `dout_x` holds the port's power-up value. Before any write, the array holds `INIT_IMAGE`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports, rising edge |
| ce_a | input | 1 | Port A clock enable |
| srst_a | input | 1 | Port A read-register synchronous reset, active high |
| be_a | input | 4 | Port A 9-bit lane write enables |
| addr_a | input | AW_A | Port A word address |
| din_a | input | WIDTH_A | Port A write data |
| dout_a | output | WIDTH_A | Port A registered read data |
| ce_b | input | 1 | Port B clock enable |
| srst_b | input | 1 | Port B read-register synchronous reset, active high |
| be_b | input | 4 | Port B 9-bit lane write enables |
| addr_b | input | AW_B | Port B word address |
| din_b | input | WIDTH_B | Port B write data |
| dout_b | output | WIDTH_B | Port B registered read data |

## Verification
The bench builds two instances, both with `ADDR1_W` = 10, which gives a 1152-bit array. The first pairs a 36-bit new-data port with a 9-bit old-data port over a nonzero image. This exercises a four-to-one word ratio, single-lane merges and cross-port reads of cells written in the same cycle. The second pairs a 4-bit hold port with an 18-bit new-data port over a zeroed array. This covers a sub-lane nibble sitting inside one lane of a wider word, and lane enables that a narrow port must ignore.

// File: rtl/tdp_mw_pkg.sv
package tdp_mw_pkg;

    localparam int LANE_W    = 9;
    localparam int MAX_LANES = 4;
    localparam int MAX_W     = LANE_W * MAX_LANES;

    // Read-register behaviour on a cycle in which the port writes
    typedef enum logic [1:0] {
        WM_NO_CHANGE   = 2'd0,
        WM_WRITE_FIRST = 2'd1,
        WM_READ_FIRST  = 2'd2
    } wr_mode_e;

    // Per-port control bundle for the read register
    typedef struct packed {
        logic en;
        logic rst;
        logic wr;
    } rd_ctl_t;

    // Address bits lost relative to the 1-bit view
    function automatic int width_shift(int w);
        case (w)
            1:       return 0;
            2:       return 1;
            4:       return 2;
            9:       return 3;
            18:      return 4;
            36:      return 5;
            default: return 0;
        endcase
    endfunction

    function automatic int port_abits(int a1, int w);
        return a1 - width_shift(w);
    endfunction

    function automatic int port_lanes(int w);
        return (w < LANE_W) ? 1 : w / LANE_W;
    endfunction

    function automatic int lane_of(int w, int bitpos);
        return (w < LANE_W) ? 0 : bitpos / LANE_W;
    endfunction

    // Flat array size: the 9-bit view has a1-3 address bits
    function automatic int array_bits(int a1);
        return LANE_W * (1 << (a1 - 3));
    endfunction

endpackage

// File: rtl/tdp_mw_lane_mask.sv
module tdp_mw_lane_mask #(
    parameter int W = 36
) (
    input  logic [tdp_mw_pkg::MAX_LANES-1:0] be,
    output logic [W-1:0]                     mask,
    output logic                             wr_any
);
    localparam int LANES = tdp_mw_pkg::port_lanes(W);

    // Each data bit follows the enable of the lane it belongs to
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign mask[i] = be[tdp_mw_pkg::lane_of(W, i)];
    end

    assign wr_any = |be[LANES-1:0];

    // Enable bits beyond the port's lanes have no function
    logic unused_be;
    assign unused_be = ^be;

endmodule

// File: rtl/tdp_mw_array.sv
module tdp_mw_array #(
    parameter int ADDR1_W = 10,
    parameter int WIDTH_A = 36,
    parameter int WIDTH_B = 36,
    parameter logic [tdp_mw_pkg::array_bits(ADDR1_W)-1:0] INIT_IMAGE = '0,
    localparam int TOTAL = tdp_mw_pkg::array_bits(ADDR1_W),
    localparam int IDXW  = $clog2(TOTAL),
    localparam int AW_A  = tdp_mw_pkg::port_abits(ADDR1_W, WIDTH_A),
    localparam int AW_B  = tdp_mw_pkg::port_abits(ADDR1_W, WIDTH_B)
) (
    input  logic               clk,
    input  logic               ce_a,
    input  logic [AW_A-1:0]    addr_a,
    input  logic [WIDTH_A-1:0] mask_a,
    input  logic [WIDTH_A-1:0] din_a,
    output logic [WIDTH_A-1:0] old_a,
    input  logic               ce_b,
    input  logic [AW_B-1:0]    addr_b,
    input  logic [WIDTH_B-1:0] mask_b,
    input  logic [WIDTH_B-1:0] din_b,
    output logic [WIDTH_B-1:0] old_b
);
    logic [TOTAL-1:0] mem = INIT_IMAGE;
    logic [IDXW-1:0]  base_a;
    logic [IDXW-1:0]  base_b;

    // Word n of a width-W view starts at flat bit n*W
    assign base_a = IDXW'(addr_a) * IDXW'(WIDTH_A);
    assign base_b = IDXW'(addr_b) * IDXW'(WIDTH_B);

    // Pre-edge contents seen by each port
    assign old_a = mem[base_a +: WIDTH_A];
    assign old_b = mem[base_b +: WIDTH_B];

    // Port B is applied last, so it lands on overlapping bits
    always_ff @(posedge clk) begin
        if (ce_a) begin
            for (int i = 0; i < WIDTH_A; i++) begin
                if (mask_a[i]) begin
                    mem[base_a + IDXW'(i)] <= din_a[i];
                end
            end
        end
        if (ce_b) begin
            for (int i = 0; i < WIDTH_B; i++) begin
                if (mask_b[i]) begin
                    mem[base_b + IDXW'(i)] <= din_b[i];
                end
            end
        end
    end

endmodule

// File: rtl/tdp_mw_rdport.sv
module tdp_mw_rdport #(
    parameter int                   W        = 36,
    parameter tdp_mw_pkg::wr_mode_e MODE     = tdp_mw_pkg::WM_NO_CHANGE,
    parameter logic [W-1:0]         RST_VAL  = '0,
    parameter logic [W-1:0]         INIT_VAL = '0
) (
    input  logic                clk,
    input  tdp_mw_pkg::rd_ctl_t ctl,
    input  logic [W-1:0]        old_word,
    input  logic [W-1:0]        din,
    input  logic [W-1:0]        mask,
    output logic [W-1:0]        dout
);
    logic [W-1:0] q = INIT_VAL;
    logic [W-1:0] merged;
    logic [W-1:0] on_write;
    logic [W-1:0] nxt;

    assign merged = (old_word & ~mask) | (din & mask);

    always_comb begin
        case (MODE)
            tdp_mw_pkg::WM_WRITE_FIRST: on_write = merged;
            tdp_mw_pkg::WM_READ_FIRST:  on_write = old_word;
            default:                    on_write = q;
        endcase
    end

    // Reset wins, and only counts on an enabled cycle
    always_comb begin
        nxt = q;
        if (ctl.en) begin
            if (ctl.rst) begin
                nxt = RST_VAL;
            end else if (ctl.wr) begin
                nxt = on_write;
            end else begin
                nxt = old_word;
            end
        end
    end

    always_ff @(posedge clk) begin
        q <= nxt;
    end

    assign dout = q;

endmodule

// File: rtl/tdp_mw_ram.sv
module tdp_mw_ram #(
    parameter int                   ADDR1_W = 10,
    parameter int                   WIDTH_A = 36,
    parameter int                   WIDTH_B = 36,
    parameter tdp_mw_pkg::wr_mode_e MODE_A  = tdp_mw_pkg::WM_NO_CHANGE,
    parameter tdp_mw_pkg::wr_mode_e MODE_B  = tdp_mw_pkg::WM_NO_CHANGE,
    parameter logic [35:0]          RST_A   = '0,
    parameter logic [35:0]          RST_B   = '0,
    parameter logic [35:0]          INIT_A  = '0,
    parameter logic [35:0]          INIT_B  = '0,
    parameter logic [tdp_mw_pkg::array_bits(ADDR1_W)-1:0] INIT_IMAGE = '0,
    localparam int AW_A = tdp_mw_pkg::port_abits(ADDR1_W, WIDTH_A),
    localparam int AW_B = tdp_mw_pkg::port_abits(ADDR1_W, WIDTH_B)
) (
    input  logic               clk,
    input  logic               ce_a,
    input  logic               srst_a,
    input  logic [3:0]         be_a,
    input  logic [AW_A-1:0]    addr_a,
    input  logic [WIDTH_A-1:0] din_a,
    output logic [WIDTH_A-1:0] dout_a,
    input  logic               ce_b,
    input  logic               srst_b,
    input  logic [3:0]         be_b,
    input  logic [AW_B-1:0]    addr_b,
    input  logic [WIDTH_B-1:0] din_b,
    output logic [WIDTH_B-1:0] dout_b
);
    logic [WIDTH_A-1:0]  mask_a;
    logic [WIDTH_B-1:0]  mask_b;
    logic                wr_any_a;
    logic                wr_any_b;
    logic [WIDTH_A-1:0]  old_a;
    logic [WIDTH_B-1:0]  old_b;
    tdp_mw_pkg::rd_ctl_t ctl_a;
    tdp_mw_pkg::rd_ctl_t ctl_b;

    tdp_mw_lane_mask #(.W(WIDTH_A)) lanes_a_i (
        .be     (be_a),
        .mask   (mask_a),
        .wr_any (wr_any_a)
    );

    tdp_mw_lane_mask #(.W(WIDTH_B)) lanes_b_i (
        .be     (be_b),
        .mask   (mask_b),
        .wr_any (wr_any_b)
    );

    tdp_mw_array #(
        .ADDR1_W    (ADDR1_W),
        .WIDTH_A    (WIDTH_A),
        .WIDTH_B    (WIDTH_B),
        .INIT_IMAGE (INIT_IMAGE)
    ) array_i (
        .clk    (clk),
        .ce_a   (ce_a),
        .addr_a (addr_a),
        .mask_a (mask_a),
        .din_a  (din_a),
        .old_a  (old_a),
        .ce_b   (ce_b),
        .addr_b (addr_b),
        .mask_b (mask_b),
        .din_b  (din_b),
        .old_b  (old_b)
    );

    assign ctl_a = '{en: ce_a, rst: srst_a, wr: wr_any_a};
    assign ctl_b = '{en: ce_b, rst: srst_b, wr: wr_any_b};

    tdp_mw_rdport #(
        .W        (WIDTH_A),
        .MODE     (MODE_A),
        .RST_VAL  (RST_A[WIDTH_A-1:0]),
        .INIT_VAL (INIT_A[WIDTH_A-1:0])
    ) rd_a_i (
        .clk      (clk),
        .ctl      (ctl_a),
        .old_word (old_a),
        .din      (din_a),
        .mask     (mask_a),
        .dout     (dout_a)
    );

    tdp_mw_rdport #(
        .W        (WIDTH_B),
        .MODE     (MODE_B),
        .RST_VAL  (RST_B[WIDTH_B-1:0]),
        .INIT_VAL (INIT_B[WIDTH_B-1:0])
    ) rd_b_i (
        .clk      (clk),
        .ctl      (ctl_b),
        .old_word (old_b),
        .din      (din_b),
        .mask     (mask_b),
        .dout     (dout_b)
    );

endmodule

// File: rtl/tdp_mw_chk.sv
module tdp_mw_chk #(
    parameter int                   WIDTH_A = 36,
    parameter int                   WIDTH_B = 36,
    parameter tdp_mw_pkg::wr_mode_e MODE_A  = tdp_mw_pkg::WM_NO_CHANGE,
    parameter tdp_mw_pkg::wr_mode_e MODE_B  = tdp_mw_pkg::WM_NO_CHANGE,
    parameter logic [35:0]          RST_A   = '0,
    parameter logic [35:0]          RST_B   = '0
) (
    input logic               clk,
    input logic               ce_a,
    input logic               srst_a,
    input logic [3:0]         be_a,
    input logic [WIDTH_A-1:0] din_a,
    input logic [WIDTH_A-1:0] dout_a,
    input logic               ce_b,
    input logic               srst_b,
    input logic [3:0]         be_b,
    input logic [WIDTH_B-1:0] din_b,
    input logic [WIDTH_B-1:0] dout_b
);
    localparam int LA = tdp_mw_pkg::port_lanes(WIDTH_A);
    localparam int LB = tdp_mw_pkg::port_lanes(WIDTH_B);

    // R3
    ce_low_hold_a_chk: assert property (@(posedge clk) disable iff (srst_a)
        !ce_a |=> $stable(dout_a));

    // R3
    ce_low_hold_b_chk: assert property (@(posedge clk) disable iff (srst_b)
        !ce_b |=> $stable(dout_b));

    // R9
    srst_load_a_chk: assert property (@(posedge clk)
        ce_a && srst_a |=> dout_a == RST_A[WIDTH_A-1:0]);

    // R9
    srst_load_b_chk: assert property (@(posedge clk)
        ce_b && srst_b |=> dout_b == RST_B[WIDTH_B-1:0]);

    if (MODE_A == tdp_mw_pkg::WM_NO_CHANGE) begin : g_hold_a
        // R5
        hold_on_write_a_chk: assert property (@(posedge clk) disable iff (srst_a)
            ce_a && !srst_a && (|be_a[LA-1:0]) |=> $stable(dout_a));
    end
    if (MODE_B == tdp_mw_pkg::WM_NO_CHANGE) begin : g_hold_b
        // R5
        hold_on_write_b_chk: assert property (@(posedge clk) disable iff (srst_b)
            ce_b && !srst_b && (|be_b[LB-1:0]) |=> $stable(dout_b));
    end
    if (MODE_A == tdp_mw_pkg::WM_WRITE_FIRST) begin : g_new_a
        // R6
        full_write_echo_a_chk: assert property (@(posedge clk) disable iff (srst_a)
            ce_a && !srst_a && (&be_a[LA-1:0]) |=> dout_a == $past(din_a));
    end
    if (MODE_B == tdp_mw_pkg::WM_WRITE_FIRST) begin : g_new_b
        // R6
        full_write_echo_b_chk: assert property (@(posedge clk) disable iff (srst_b)
            ce_b && !srst_b && (&be_b[LB-1:0]) |=> dout_b == $past(din_b));
    end

    logic unused_chk;
    assign unused_chk = ^{be_a, be_b, din_a, din_b};

endmodule

bind tdp_mw_ram tdp_mw_chk #(
    .WIDTH_A (WIDTH_A),
    .WIDTH_B (WIDTH_B),
    .MODE_A  (MODE_A),
    .MODE_B  (MODE_B),
    .RST_A   (RST_A),
    .RST_B   (RST_B)
) chk_i (
    .clk    (clk),
    .ce_a   (ce_a),
    .srst_a (srst_a),
    .be_a   (be_a),
    .din_a  (din_a),
    .dout_a (dout_a),
    .ce_b   (ce_b),
    .srst_b (srst_b),
    .be_b   (be_b),
    .din_b  (din_b),
    .dout_b (dout_b)
);

// File: tb/tdp_mw_ram_tb.sv
module tdp_mw_ram_tb_top;

    localparam int TOT = 1152;
    // Ports 0,1 belong to dut_i (A,B); ports 2,3 to dut2_i (A,B)
    localparam int          PW[4]    = '{36, 9, 4, 18};
    localparam int          PAW[4]   = '{5, 7, 8, 6};
    localparam int          PM[4]    = '{1, 2, 0, 1};
    localparam logic [35:0] PRST[4]  = '{36'h0AB, 36'h155, 36'h9, 36'h2A5A5};
    localparam logic [35:0] PINIT[4] = '{36'h123, 36'h0F0, 36'h6, 36'h1C3C3};
    localparam logic [TOT-1:0] IMG0  = {32{36'h9A5C31E7D}};

    logic clk = 1'b0;
    always #4ns clk = ~clk;

    logic        ce   [4];
    logic        srst [4];
    logic [3:0]  be   [4];
    logic [15:0] addr [4];
    logic [35:0] din  [4];

    logic [35:0] dout0;
    logic [8:0]  dout1;
    logic [3:0]  dout2;
    logic [17:0] dout3;

    tdp_mw_ram #(
        .ADDR1_W (10), .WIDTH_A (36), .WIDTH_B (9),
        .MODE_A (tdp_mw_pkg::WM_WRITE_FIRST), .MODE_B (tdp_mw_pkg::WM_READ_FIRST),
        .RST_A (36'h0AB), .RST_B (36'h155), .INIT_A (36'h123), .INIT_B (36'h0F0),
        .INIT_IMAGE (IMG0)
    ) dut_i (
        .clk (clk),
        .ce_a (ce[0]), .srst_a (srst[0]), .be_a (be[0]), .addr_a (addr[0][4:0]),
        .din_a (din[0][35:0]), .dout_a (dout0),
        .ce_b (ce[1]), .srst_b (srst[1]), .be_b (be[1]), .addr_b (addr[1][6:0]),
        .din_b (din[1][8:0]), .dout_b (dout1)
    );

    tdp_mw_ram #(
        .ADDR1_W (10), .WIDTH_A (4), .WIDTH_B (18),
        .MODE_A (tdp_mw_pkg::WM_NO_CHANGE), .MODE_B (tdp_mw_pkg::WM_WRITE_FIRST),
        .RST_A (36'h9), .RST_B (36'h2A5A5), .INIT_A (36'h6), .INIT_B (36'h1C3C3)
    ) dut2_i (
        .clk (clk),
        .ce_a (ce[2]), .srst_a (srst[2]), .be_a (be[2]), .addr_a (addr[2][7:0]),
        .din_a (din[2][3:0]), .dout_a (dout2),
        .ce_b (ce[3]), .srst_b (srst[3]), .be_b (be[3]), .addr_b (addr[3][5:0]),
        .din_b (din[3][17:0]), .dout_b (dout3)
    );

    typedef struct {
        int          due;
        int          p;
        logic [35:0] exp;
        string       tag;
    } item_t;

    item_t          sb_q[$];
    logic [TOT-1:0] shadow [2];
    logic [35:0]    held [4];
    int             cyc      = 0;
    int             n_checks = 0;
    int             n_fail   = 0;
    bit             done     = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [35:0] wmask(int w);
        return (36'(1) << w) - 36'(1);
    endfunction

    function automatic logic [35:0] dout_of(int p);
        case (p)
            0:       return dout0;
            1:       return 36'(dout1);
            2:       return 36'(dout2);
            default: return 36'(dout3);
        endcase
    endfunction

    function automatic int lane(int w, int i);
        return (w < 9) ? 0 : i / 9;
    endfunction

    function automatic logic [35:0] rd_sh(int p);
        logic [35:0] r;
        int          b;
        r = '0;
        b = int'(addr[p]) * PW[p];
        for (int i = 0; i < PW[p]; i++) r[i] = shadow[p/2][b+i];
        return r;
    endfunction

    function automatic bit writes(int p);
        int ln;
        ln = (PW[p] < 9) ? 1 : PW[p] / 9;
        return ce[p] && (|(be[p] & 4'((1 << ln) - 1)));
    endfunction

    task automatic check(string tag, int p, logic [35:0] got, logic [35:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s port%0d got %h exp %h", tag, p, got, exp);
        end
    endtask

    task automatic set(int p, logic c, logic r, logic [3:0] b, int a, logic [35:0] d);
        ce[p] = c; srst[p] = r; be[p] = b; addr[p] = 16'(a); din[p] = d;
    endtask

    task automatic idle();
        for (int p = 0; p < 4; p++) set(p, 1'b0, 1'b0, 4'h0, 0, '0);
    endtask

    // Driver: expected read-register values from the requirements, then one edge
    task automatic commit(string tag);
        logic [35:0] old [4];
        logic [35:0] nxt [4];
        logic [35:0] mrg;
        for (int p = 0; p < 4; p++) old[p] = rd_sh(p);
        for (int p = 0; p < 4; p++) begin
            mrg = old[p];
            for (int i = 0; i < PW[p]; i++) if (be[p][lane(PW[p], i)]) mrg[i] = din[p][i];
            if (!ce[p])           nxt[p] = held[p];
            else if (srst[p])     nxt[p] = PRST[p] & wmask(PW[p]);
            else if (writes(p)) begin
                if (PM[p] == 0)      nxt[p] = held[p];
                else if (PM[p] == 1) nxt[p] = mrg;
                else                 nxt[p] = old[p];
            end
            else                  nxt[p] = old[p];
        end
        for (int p = 0; p < 4; p++) begin
            if (ce[p]) begin
                for (int i = 0; i < PW[p]; i++) begin
                    if (be[p][lane(PW[p], i)]) shadow[p/2][int'(addr[p]) * PW[p] + i] = din[p][i];
                end
            end
        end
        for (int p = 0; p < 4; p++) begin
            item_t it;
            held[p] = nxt[p];
            it.due = cyc + 1; it.p = p; it.exp = nxt[p]; it.tag = tag;
            sb_q.push_back(it);
        end
        @(negedge clk);
    endtask

    // Monitor: compare each expected item once its edge has passed
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
            item_t it;
            it = sb_q.pop_front();
            check(it.tag, it.p, dout_of(it.p), it.exp);
        end
    end

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8ns * 150000);
        n_fail++;
        $display("FAIL watchdog R4 run did not complete");
        finish_up();
    end

    initial begin
        shadow[0] = IMG0;
        shadow[1] = '0;
        for (int p = 0; p < 4; p++) held[p] = PINIT[p] & wmask(PW[p]);
        idle();
        #1ns;
        // R10: power-up register values
        for (int p = 0; p < 4; p++) check("R10 init", p, dout_of(p), PINIT[p] & wmask(PW[p]));
        @(negedge clk);

        // R3: disabled ports ignore every input, reset included
        idle();
        for (int p = 0; p < 4; p++) set(p, 1'b0, 1'b1, 4'hF, 1, 36'hFFFFFFFFF);
        commit("R3 R9 disabled");
        idle(); set(0, 1'b1, 1'b0, 4'h0, 1, '0);
        commit("R3 R4 image intact");

        // R1 R10: mapping of the initial image through each width
        idle();
        set(0, 1'b1, 1'b0, 4'h0, 3, '0);   set(1, 1'b1, 1'b0, 4'h0, 13, '0);
        set(2, 1'b1, 1'b0, 4'h0, 200, '0); set(3, 1'b1, 1'b0, 4'h0, 40, '0);
        commit("R1 R10 mapping");

        // R6 R8: full write on wide port, same-cycle read on narrow port
        idle();
        set(0, 1'b1, 1'b0, 4'hF, 2, 36'h123456789); set(1, 1'b1, 1'b0, 4'h0, 9, '0);
        commit("R6 R8 full write");
        idle(); set(1, 1'b1, 1'b0, 4'h0, 9, '0);
        commit("R1 narrow view");

        // R2 R6: one-lane merge
        idle();
        set(0, 1'b1, 1'b0, 4'b0100, 2, 36'hFFFFFFFFF); set(1, 1'b1, 1'b0, 4'h0, 10, '0);
        commit("R2 R6 lane merge");

        // R7 R8: old-data write on narrow port, wide port reads same word
        idle();
        set(1, 1'b1, 1'b0, 4'h1, 8, 36'h1AA); set(0, 1'b1, 1'b0, 4'h0, 2, '0);
        commit("R7 R8 old data");
        idle(); set(0, 1'b1, 1'b0, 4'h0, 2, '0);
        commit("R1 wide view");

        // R2: narrow port ignores upper enables
        idle(); set(1, 1'b1, 1'b0, 4'b1110, 8, 36'h0);
        commit("R2 upper enables");
        idle(); set(1, 1'b1, 1'b0, 4'h0, 8, '0);
        commit("R2 unchanged");

        // R9: reset with write, reset without enable
        idle();
        set(0, 1'b1, 1'b1, 4'hF, 5, 36'hFEDCBA987); set(1, 1'b0, 1'b1, 4'h0, 0, '0);
        commit("R9 reset");
        idle(); set(0, 1'b1, 1'b0, 4'h0, 5, '0);
        commit("R9 write kept");

        // R5: hold policy on the 4-bit port
        idle();
        set(2, 1'b1, 1'b0, 4'h1, 7, 36'hC); set(3, 1'b1, 1'b0, 4'h0, 1, '0);
        commit("R5 R8 hold");
        idle(); set(2, 1'b1, 1'b0, 4'b1110, 7, 36'h3);
        commit("R2 R5 no lane");
        idle();
        set(3, 1'b1, 1'b0, 4'b0010, 1, 36'h3FFFF); set(2, 1'b1, 1'b0, 4'h0, 7, '0);
        commit("R6 R8 upper lane");
        idle(); set(2, 1'b1, 1'b0, 4'h0, 7, '0);
        commit("R1 nibble view");
        idle(); set(3, 1'b0, 1'b0, 4'hF, 1, 36'h0);
        commit("R3 no write");
        idle(); set(3, 1'b1, 1'b0, 4'h0, 1, '0);
        commit("R3 R4 readback");

        // R1 R4: mixed traffic, at most one writer per memory per cycle
        for (int n = 0; n < 80; n++) begin
            idle();
            for (int k = 0; k < 2; k++) begin
                int wp;
                int rp;
                wp = 2 * k + int'($urandom_range(0, 1));
                rp = (wp % 2 == 0) ? wp + 1 : wp - 1;
                set(wp, ($urandom % 5) != 0, 1'b0, 4'($urandom),
                    int'($urandom_range(0, (1 << PAW[wp]) - 1)), {4'($urandom), 32'($urandom)});
                set(rp, ($urandom % 4) != 0, ($urandom % 8) == 0, 4'h0,
                    int'($urandom_range(0, (1 << PAW[rp]) - 1)), '0);
            end
            commit("R1 R4 mixed");
        end

        idle();
        @(negedge clk);
        @(negedge clk);
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL R4 pending items got %0d exp 0", sb_q.size());
        end
        finish_up();
    end

endmodule